// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide host side of a three-channel interval timer. It sits between a simple register bus and the channel counters. It decodes control bytes written at offset 3. For each channel it keeps the byte access mode, the operating mode and the decimal flag, along with the state that orders bytes on reads and writes. Reload values written one byte at a time are assembled into 16-bit words and handed to the counter as a one-cycle load pulse. Reads return a held status byte, a frozen copy of the count, or the live count. The live count comes from the counter over a per-channel input bus.

The counters are outside this block. Each channel supplies its live 16-bit count and its output level. In return it receives load pulses with values and its stored operating mode. A data write at offset 0, 1 or 2 goes to that channel. A control write at offset 3 either programs a channel, freezes its count, or issues a multi-channel read-back that can freeze count and status separately. Read data is combinational from the addressed register. The side effects of a read (advancing the byte order, releasing held values) take effect at the clock edge where `rd_en` is high.

Top module: `tick_ctl_regs`

## Requirements
- R1: After reset every channel is in word access (code 3) with operating mode 0 and decimal flag 0, no count or status is held, `load_valid` is low, and the first live-count read returns the low byte.
- R2: A control byte with bits 7:6 equal to 0, 1 or 2 and a non-zero access code in bits 5:4 stores the access code (1 low only, 2 high only, 3 word), the operating mode from bits 3:1 (shown on `chan_mode` at 3 bits per channel) and bit 0 as the decimal flag, and returns that channel's read and write byte order to the low byte.
- R3: In low-only access a data write loads `{8'h00, byte}`, in high-only access it loads `{byte, 8'h00}`, and every load shows as `load_valid` high for exactly the cycle after the write, with `load_value` on the channel's 16-bit slice.
- R4: In word access the first data write only stores the low byte and produces no load, and the second loads `{second, first}`.
- R5: A control byte with access code 0 freezes the selected channel's live count, and a further freeze request while a frozen count is still unread leaves the first frozen value in place.
- R6: A frozen count is read in the channel's access mode: word access gives the low byte then the high byte, while low-only or high-only give one byte. After that the hold is released and reads return the live count again.
- R7: Without a held value, reads give the live low byte in low-only access and the live high byte in high-only access. In word access they alternate low, high, low.
- R8: A control byte with bits 7:6 equal to 3 is a read-back: bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 freezes the count and bit 4 at 0 captures the status byte `{out, 0, access[1:0], mode[2:0], decimal}`.
- R9: A status capture request while a status is still unread is ignored. A read returns a pending status first, then a frozen count, then the live count.
- R10: A read at offset 3 returns 8'hFF and changes no byte order and no held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte at `addr` |
| rd_en | input | 1 | Read strobe; side effects at the clock edge |
| addr | input | 2 | Offset: 0..2 channel data, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| live_count | input | 48 | Live count, 16 bits per channel, channel 0 in the low bits |
| out_level | input | 3 | Counter output level per channel |
| load_valid | output | 3 | One-cycle load pulse per channel |
| load_value | output | 48 | Reload value, 16 bits per channel |
| chan_mode | output | 9 | Stored operating mode, 3 bits per channel |

## Verification
The byte ordering is driven through every access mode. Low-only and high-only writes and reads tell the two byte lanes apart. Two word writes with different bytes expose a swapped or missing lane. A control byte dropped between the two halves of a word write shows whether the byte order is reset. Count freezes are issued twice with the live count changed in between, and status captures twice with the output level changed in between. Both separate a value that is held from one that is re-captured. One read-back selects two channels at once, and another carries a pending status alongside a frozen count, so channel selection and the status-then-count-then-live priority are checked separately. Reads at offset 3 are placed between the two halves of a frozen word to show they leave the sequence alone.

// File: rtl/tick_ctl_pkg.sv
package tick_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // access code; LATCH doubles as "nothing held" in the hold tracker
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e               acc;
        logic [MODE_W-1:0]  mode;
        logic               bcd;
        logic               wr_hi;     // next word write is the high byte
        logic               rd_hi;     // next live word read is the high byte
        logic [BYTE_W-1:0]  lo_byte;
        acc_e               cnt_pend;  // byte order of the frozen count
        logic [CNT_W-1:0]   cnt_hold;
        logic               sts_pend;
        logic [BYTE_W-1:0]  sts_hold;
        logic               load_v;
        logic [CNT_W-1:0]   load_val;
    } chan_state_t;

endpackage

// File: rtl/tick_ctl_decode.sv
module tick_ctl_decode
    import tick_ctl_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [NCH-1:0]     cmd_set,
    output logic [NCH-1:0]     latch_cnt,
    output logic [NCH-1:0]     latch_sts,
    output logic [NCH-1:0]     wr_stb,
    output logic [NCH-1:0]     rd_stb
);

    localparam logic [1:0] CTRL_OFS = 2'd3;

    logic       is_ctrl;
    logic [1:0] sel;
    logic [1:0] acc;
    logic       rb;

    assign is_ctrl = wr_en && (addr == CTRL_OFS);
    assign sel     = wdata[7:6];
    assign acc     = wdata[5:4];
    assign rb      = (sel == 2'd3);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [1:0] IDX = 2'(i);
        logic rb_pick;
        assign rb_pick      = is_ctrl && rb && wdata[1+i];
        assign cmd_set[i]   = is_ctrl && (sel == IDX) && (acc != 2'd0);
        assign latch_cnt[i] = (is_ctrl && (sel == IDX) && (acc == 2'd0))
                            || (rb_pick && !wdata[5]);
        assign latch_sts[i] = rb_pick && !wdata[4];
        assign wr_stb[i]    = wr_en && (addr == IDX);
        assign rd_stb[i]    = rd_en && (addr == IDX);
    end

endmodule

// File: rtl/tick_ctl_chan.sv
module tick_ctl_chan
    import tick_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_set,
    input  logic [BYTE_W-1:0]  cmd_byte,
    input  logic               latch_cnt,
    input  logic               latch_sts,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [CNT_W-1:0]   live_cnt,
    input  logic               out_lvl,
    output logic [BYTE_W-1:0]  rdata,
    output logic               load_v,
    output logic [CNT_W-1:0]   load_val,
    output logic [MODE_W-1:0]  mode
);

    chan_state_t st_d, st_q;

    localparam chan_state_t RST_ST = '{
        acc:      ACC_WORD,
        mode:     '0,
        bcd:      1'b0,
        wr_hi:    1'b0,
        rd_hi:    1'b0,
        lo_byte:  '0,
        cnt_pend: ACC_LATCH,
        cnt_hold: '0,
        sts_pend: 1'b0,
        sts_hold: '0,
        load_v:   1'b0,
        load_val: '0
    };

    // read data: status, then frozen count, then live count
    always_comb begin
        rdata = live_cnt[BYTE_W-1:0];
        if (st_q.sts_pend) begin
            rdata = st_q.sts_hold;
        end else if (st_q.cnt_pend != ACC_LATCH) begin
            rdata = (st_q.cnt_pend == ACC_HI) ? st_q.cnt_hold[CNT_W-1:BYTE_W]
                                              : st_q.cnt_hold[BYTE_W-1:0];
        end else begin
            unique case (st_q.acc)
                ACC_HI:   rdata = live_cnt[CNT_W-1:BYTE_W];
                ACC_WORD: rdata = st_q.rd_hi ? live_cnt[CNT_W-1:BYTE_W]
                                             : live_cnt[BYTE_W-1:0];
                default:  rdata = live_cnt[BYTE_W-1:0];
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.load_v = 1'b0;

        if (rd_stb) begin
            if (st_q.sts_pend) begin
                st_d.sts_pend = 1'b0;
            end else if (st_q.cnt_pend != ACC_LATCH) begin
                st_d.cnt_pend = (st_q.cnt_pend == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end

        if (wr_stb) begin
            unique case (st_q.acc)
                ACC_HI: begin
                    st_d.load_v   = 1'b1;
                    st_d.load_val = {cmd_byte, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (st_q.wr_hi) begin
                        st_d.load_v   = 1'b1;
                        st_d.load_val = {cmd_byte, st_q.lo_byte};
                        st_d.wr_hi    = 1'b0;
                    end else begin
                        st_d.lo_byte  = cmd_byte;
                        st_d.wr_hi    = 1'b1;
                    end
                end
                default: begin
                    st_d.load_v   = 1'b1;
                    st_d.load_val = {{BYTE_W{1'b0}}, cmd_byte};
                end
            endcase
        end

        if (cmd_set) begin
            st_d.acc   = acc_e'(cmd_byte[5:4]);
            st_d.mode  = cmd_byte[3:1];
            st_d.bcd   = cmd_byte[0];
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (latch_cnt && (st_q.cnt_pend == ACC_LATCH)) begin
            st_d.cnt_hold = live_cnt;
            st_d.cnt_pend = st_q.acc;
        end

        if (latch_sts && !st_q.sts_pend) begin
            st_d.sts_hold = {out_lvl, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
            st_d.sts_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign load_v   = st_q.load_v;
    assign load_val = st_q.load_val;
    assign mode     = st_q.mode;

    // R9: a pending status is not overwritten before it is read
    a_r9_sts_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sts_pend && !rd_stb |=> st_q.sts_pend && $stable(st_q.sts_hold));

    // R5: a frozen count survives further freeze requests until read
    a_r5_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt_pend != ACC_LATCH) && !rd_stb |=> $stable(st_q.cnt_hold));

    // R4: the first half of a word write never loads
    a_r4_word_lo_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && (st_q.acc == ACC_WORD) && !st_q.wr_hi |=> !load_v);

    // R9: a read with status pending leaves the count hold order untouched
    a_r9_sts_first: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && st_q.sts_pend && !latch_cnt |=> $stable(st_q.cnt_pend));

    // R3: a load pulse only follows a data write
    a_r3_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> !load_v);

endmodule

// File: rtl/tick_ctl_regs.sv
module tick_ctl_regs
    import tick_ctl_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [1:0]              addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH*CNT_W-1:0]    live_count,
    input  logic [NCH-1:0]          out_level,
    output logic [NCH-1:0]          load_valid,
    output logic [NCH*CNT_W-1:0]    load_value,
    output logic [NCH*MODE_W-1:0]   chan_mode
);

    localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

    logic [NCH-1:0]        cmd_set, latch_cnt, latch_sts, wr_stb, rd_stb;
    logic [BYTE_W-1:0]     ch_rdata [NCH];

    tick_ctl_decode #(.NCH(NCH)) u_dec (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cmd_set   (cmd_set),
        .latch_cnt (latch_cnt),
        .latch_sts (latch_sts),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tick_ctl_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_set   (cmd_set[i]),
            .cmd_byte  (wdata),
            .latch_cnt (latch_cnt[i]),
            .latch_sts (latch_sts[i]),
            .wr_stb    (wr_stb[i]),
            .rd_stb    (rd_stb[i]),
            .live_cnt  (live_count[i*CNT_W +: CNT_W]),
            .out_lvl   (out_level[i]),
            .rdata     (ch_rdata[i]),
            .load_v    (load_valid[i]),
            .load_val  (load_value[i*CNT_W +: CNT_W]),
            .mode      (chan_mode[i*MODE_W +: MODE_W])
        );
    end

    always_comb begin
        rdata = IDLE_BYTE;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = ch_rdata[i];
        end
    end

    // R10: the control offset reads as all ones
    a_r10_ctrl_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == 2'd3) |-> rdata == IDLE_BYTE);

    // R3: one data write per cycle gives at most one load pulse
    a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_valid));

endmodule

// File: tb/sim_tick_ctl_regs.sv
module sim_tick_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [47:0] live_count = 48'd0;
    logic [2:0]  out_level = 3'd0;
    logic [2:0]  load_valid;
    logic [47:0] load_value;
    logic [8:0]  chan_mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tick_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count),
        .out_level(out_level), .load_valid(load_valid),
        .load_value(load_value), .chan_mode(chan_mode)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        live_count[ch*16 +: 16] = v;
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        do_rd(a, d);
        chk(req, {8'd0, d}, {8'd0, exp});
    endtask

    task automatic wr_chk_load(input string req, input int ch, input logic [7:0] d,
                               input logic v, input logic [15:0] val);
        do_wr(2'(ch), d);
        chk(req, {15'd0, load_valid[ch]}, {15'd0, v});
        if (v) chk(req, load_value[ch*16 +: 16], val);
    endtask

    task automatic t_reset;
        chk("R1 load_valid", {13'd0, load_valid}, 16'd0);
        chk("R1 mode", {7'd0, chan_mode}, 16'd0);
        set_live(0, 16'h1234);
        rd_chk("R1 first live low", 2'd0, 8'h34);
        rd_chk("R7 word live high", 2'd0, 8'h12);
    endtask

    task automatic t_single_byte;
        do_wr(2'd3, 8'h58);                     // ch1 low only, mode 4
        chk("R2 mode ch1", {13'd0, chan_mode[5:3]}, 16'd4);
        wr_chk_load("R3 low only", 1, 8'hA5, 1'b1, 16'h00A5);
        @(posedge clk); #1;
        chk("R3 pulse one cycle", {13'd0, load_valid}, 16'd0);
        do_wr(2'd3, 8'h64);                     // ch1 high only, mode 2
        chk("R2 mode ch1 again", {13'd0, chan_mode[5:3]}, 16'd2);
        wr_chk_load("R3 high only", 1, 8'h3C, 1'b1, 16'h3C00);
        set_live(1, 16'hBEEF);
        rd_chk("R7 high only", 2'd1, 8'hBE);
        rd_chk("R7 high only repeat", 2'd1, 8'hBE);
    endtask

    task automatic t_word_write;
        do_wr(2'd3, 8'hB6);                     // ch2 word, mode 3
        chk("R2 mode ch2", {13'd0, chan_mode[8:6]}, 16'd3);
        wr_chk_load("R4 first half", 2, 8'h78, 1'b0, 16'h0);
        wr_chk_load("R4 second half", 2, 8'h56, 1'b1, 16'h5678);
        wr_chk_load("R4 dangling half", 2, 8'h11, 1'b0, 16'h0);
        do_wr(2'd3, 8'hB6);
        wr_chk_load("R2 order reset", 2, 8'h22, 1'b0, 16'h0);
        wr_chk_load("R2 order reset load", 2, 8'h33, 1'b1, 16'h3322);
    endtask

    task automatic t_latch;
        set_live(0, 16'h1234);
        do_wr(2'd3, 8'h00);
        set_live(0, 16'h9A5B);
        do_wr(2'd3, 8'h00);                     // ignored
        rd_chk("R5 R6 frozen low", 2'd0, 8'h34);
        rd_chk("R6 frozen high", 2'd0, 8'h12);
        rd_chk("R6 released live", 2'd0, 8'h5B);
        rd_chk("R7 live high", 2'd0, 8'h9A);
        set_live(1, 16'hBEEF);
        do_wr(2'd3, 8'h40);                     // freeze ch1 (high only)
        set_live(1, 16'h1177);
        rd_chk("R6 frozen high only", 2'd1, 8'hBE);
        rd_chk("R6 single byte release", 2'd1, 8'h11);
    endtask

    task automatic t_readback;
        set_live(2, 16'h4321);
        out_level = 3'b100;
        do_wr(2'd3, 8'hC8);                     // count+status ch2
        out_level = 3'b000;
        do_wr(2'd3, 8'hE8);                     // status only, ignored
        set_live(2, 16'h0000);
        rd_chk("R8 R9 status first", 2'd2, 8'hB6);
        rd_chk("R9 then count low", 2'd2, 8'h21);
        rd_chk("R9 then count high", 2'd2, 8'h43);
        rd_chk("R9 then live", 2'd2, 8'h00);
        do_wr(2'd3, 8'h5B);                     // ch1 low only, mode 5, decimal
        set_live(0, 16'h0F0E);
        set_live(1, 16'h00C7);
        do_wr(2'd3, 8'hD6);                     // count ch0 and ch1
        set_live(0, 16'hFFFF);
        set_live(1, 16'hFFFF);
        rd_chk("R8 ch0 low", 2'd0, 8'h0E);
        rd_chk("R8 ch0 high", 2'd0, 8'h0F);
        rd_chk("R8 ch1 low", 2'd1, 8'hC7);
        rd_chk("R8 ch1 released", 2'd1, 8'hFF);
        do_wr(2'd3, 8'hE4);                     // status ch1
        rd_chk("R8 status fields", 2'd1, 8'h1B);
        rd_chk("R8 status released", 2'd1, 8'hFF);
    endtask

    task automatic t_ctrl_read;
        set_live(0, 16'h2468);
        do_wr(2'd3, 8'h00);
        set_live(0, 16'hABCD);
        rd_chk("R10 ctrl ff", 2'd3, 8'hFF);
        rd_chk("R10 hold kept low", 2'd0, 8'h68);
        rd_chk("R10 ctrl ff again", 2'd3, 8'hFF);
        rd_chk("R10 hold kept high", 2'd0, 8'h24);
        rd_chk("R10 live low", 2'd0, 8'hCD);
        rd_chk("R10 live high", 2'd0, 8'hAB);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single_byte();
        t_word_write();
        t_latch();
        t_readback();
        t_ctrl_read();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule